// File: doc/BRIEF.md
# Port Disconnect Sense Timer

This block decides when a powered Ethernet port has lost its load and must be switched off. While the port is on, it runs a millisecond disconnect timer that advances whenever the load looks absent. If the timer reaches its limit, the block raises a one-cycle disconnect request. Whatever drives the power switch acts on that request.

The block has two sensing modes, chosen by a static select input.
- **DC mode:** the block watches a comparator flag that reports port current below the minimum holding level. The timer clears only after current has been present without a break for a minimum presence time. Shorter bursts of current pause the timer but do not clear it.
- **AC mode:** the block watches one strobed sample of a peak-current comparator per cycle of the low-frequency probe tone, roughly every 9 ms at about 110 Hz. A single poor sample marks the load as absent. Only two good samples in a row clear the timer.

Dropping the port-on input clears every counter, so each power-on cycle starts fresh. The comparators, the tone generator and the switch itself are outside the block.

Top module: `port_discon_sense`

## Requirements
- R1: After reset (synchronous, active low), `disc_req` is 0 and all counters are zero.
- R2: In DC mode (`osc_tied_low` = 1), the timer advances by one on each `tick_1ms` pulse while `port_on` = 1 and `dc_below_min` = 1. `disc_req` rises in the cycle after the edge that samples the 350th such tick (`TIMEOUT_TICKS`).
- R3: In DC mode, ticks with `dc_below_min` = 0 do not advance the timer. A presence run shorter than 20 ticks (`DC_HOLD_TICKS`) leaves the accumulated count intact.
- R4: In DC mode, 20 consecutive ticks with `dc_below_min` = 0 clear the timer to zero.
- R5: In AC mode (`osc_tied_low` = 0), the load is treated as absent from port-on, and again from any strobed sample with `ac_peak_above` = 0. While the load is absent, each tick advances the timer, and `disc_req` rises after the 350th advancing tick.
- R6: In AC mode, a single strobed sample with `ac_peak_above` = 1 does not clear the timer. The second consecutive good sample (`AC_GOOD_RUN` = 2) clears the timer and stops it until the next poor sample.
- R7: In DC mode the `ac_sample_stb` and `ac_peak_above` inputs have no effect. In AC mode the `dc_below_min` input has no effect.
- R8: While `port_on` = 0, the timer and both filters are held at zero and ticks do not advance anything.
- R9: `disc_req` is a single-cycle pulse. After it fires, the timer saturates at its limit and no further pulse occurs until the timer is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_on | input | 1 | Port is powered; 0 clears all state |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| osc_tied_low | input | 1 | 1 selects DC sensing, 0 selects AC sensing |
| dc_below_min | input | 1 | DC comparator: port current under minimum |
| ac_sample_stb | input | 1 | One-cycle strobe per probe-tone cycle |
| ac_peak_above | input | 1 | Peak comparator value at the strobe: 1 means current above threshold |
| disc_req | output | 1 | One-cycle disconnect request |

## Verification
The bench targets the expiry edge: the pulse must appear exactly after the 350th advancing tick. A design that is off by one, or that counts presence ticks, moves the pulse.

Two filter cases are probed by stopping just short of the clearing condition:
- A 19-tick presence run in DC mode must keep the count. A filter that clears too early would restart the full 350 ticks.
- A lone good sample in AC mode must also keep the count. An AC qualifier that clears on one good sample would delay or lose the pulse.

Cross-mode leakage, a saturated timer that pulses twice, and a port-off that fails to clear the count each show up as an extra pulse, a missing pulse, or a pulse at the wrong tick.

// File: rtl/dsense_pkg.sv
// Shared definitions for the port disconnect sense timer.
// Assumes the mode select is static while the port is powered.
package dsense_pkg;

    typedef enum logic {
        SENSE_AC = 1'b0,
        SENSE_DC = 1'b1
    } sense_mode_e;

    // Map the oscillator-select pin onto a sensing mode.
    function automatic sense_mode_e decode_mode(input logic osc_low);
        return osc_low ? SENSE_DC : SENSE_AC;
    endfunction

endpackage

// File: rtl/dc_presence_filter.sv
// Glitch filter for DC sensing: emits a clear strobe once current has been
// present (comparator flag low) for HOLD_TICKS consecutive ticks.
// Assumes tick is a single-cycle pulse; enable low holds the filter at zero.
module dc_presence_filter #(
    parameter int HOLD_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic below_min,
    output logic under,
    output logic clear
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_TICKS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] pres_cnt;

    // Count consecutive present ticks, restarting on any under-current reading.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || below_min) begin
            pres_cnt <= '0;
        end else if (tick && pres_cnt < HOLD_MAX) begin
            pres_cnt <= pres_cnt + 1'b1;
        end
    end

    // Decode the current-absent level and the clear on the final qualifying tick.
    always_comb begin
        under = enable && below_min;
        clear = enable && !below_min && tick && (pres_cnt == HOLD_LAST);
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pres_cnt <= HOLD_MAX);
    a_r3_under_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && below_min) |=> (pres_cnt == '0));
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pres_cnt == '0));
endmodule

// File: rtl/ac_sample_qualifier.sv
// AC sensing qualifier: tracks runs of good probe samples. A poor sample marks
// the load absent; GOOD_RUN consecutive good samples clear the timer.
// Assumes one strobe per probe-tone cycle; enable low restarts it as absent.
module ac_sample_qualifier #(
    parameter int GOOD_RUN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic peak_above,
    output logic absent,
    output logic clear
);
    localparam int RW = $clog2(GOOD_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(GOOD_RUN);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);

    logic [RW-1:0] run_cnt;
    logic          absent_q;

    // Clear once the run of good samples reaches its target.
    always_comb begin
        clear  = enable && strobe && peak_above && (run_cnt >= RUN_LAST);
        absent = absent_q;
    end

    // Track the good-sample run length, saturating at its target.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_cnt <= '0;
        end else if (strobe) begin
            if (!peak_above)            run_cnt <= '0;
            else if (run_cnt < RUN_MAX) run_cnt <= run_cnt + 1'b1;
        end
    end

    // Absent flag: set by a poor sample, dropped only by a qualified clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            absent_q <= 1'b1;
        end else if (strobe) begin
            if (!peak_above) absent_q <= 1'b1;
            else if (clear)  absent_q <= 1'b0;
        end
    end

    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_MAX);
    a_r6_bad_marks_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && strobe && !peak_above) |=> absent);
    a_r6_absent_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (absent && !clear) |=> absent);
endmodule

// File: rtl/disconnect_timer.sv
// Saturating millisecond disconnect timer. Advances on ticks while the load
// is absent, clears on request, and pulses disc_req once on reaching LIMIT.
// Assumes clear has priority over advance; port_on low forces zero.
module disconnect_timer #(
    parameter int TIMEOUT_TICKS = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_on,
    input  logic tick,
    input  logic advance,
    input  logic clear,
    output logic disc_req
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] LIMIT     = TW'(TIMEOUT_TICKS);
    localparam logic [TW-1:0] LIMIT_M1  = TW'(TIMEOUT_TICKS - 1);

    logic [TW-1:0] elapsed;
    logic          step;

    // A counting step happens only on an advancing tick below the limit.
    always_comb begin
        step = port_on && !clear && tick && advance && (elapsed < LIMIT);
    end

    // Elapsed-time counter with clear priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_on || clear) begin
            elapsed <= '0;
        end else if (step) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Register the request on the step that reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_on) begin
            disc_req <= 1'b0;
        end else begin
            disc_req <= step && (elapsed == LIMIT_M1);
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |=> !disc_req);
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= LIMIT);
    a_r2_pulse_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |-> (elapsed == LIMIT));
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (port_on && !tick && !clear) |=> $stable(elapsed));
    a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on |=> (elapsed == '0 && !disc_req));
endmodule

// File: rtl/port_discon_sense.sv
// Top of the port disconnect sense timer. Selects DC or AC load sensing,
// qualifies the load evidence and drives the shared disconnect timer.
// Assumes tick_1ms and ac_sample_stb are single-cycle pulses.
module port_discon_sense
    import dsense_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 350,
    parameter int DC_HOLD_TICKS = 20,
    parameter int AC_GOOD_RUN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_on,
    input  logic tick_1ms,
    input  logic osc_tied_low,
    input  logic dc_below_min,
    input  logic ac_sample_stb,
    input  logic ac_peak_above,
    output logic disc_req
);
    sense_mode_e mode;
    logic dc_en, ac_en;
    logic dc_under, dc_clear;
    logic ac_absent, ac_clear;
    logic advance, clear_any;

    // Decode the sensing mode and gate each path with port power.
    always_comb begin
        mode  = decode_mode(osc_tied_low);
        dc_en = port_on && (mode == SENSE_DC);
        ac_en = port_on && (mode == SENSE_AC);
    end

    dc_presence_filter #(.HOLD_TICKS(DC_HOLD_TICKS)) u_dc (
        .clk(clk), .rst_n(rst_n), .enable(dc_en), .tick(tick_1ms),
        .below_min(dc_below_min), .under(dc_under), .clear(dc_clear)
    );

    ac_sample_qualifier #(.GOOD_RUN(AC_GOOD_RUN)) u_ac (
        .clk(clk), .rst_n(rst_n), .enable(ac_en), .strobe(ac_sample_stb),
        .peak_above(ac_peak_above), .absent(ac_absent), .clear(ac_clear)
    );

    // Pick the load-absent evidence and clear source of the active mode.
    always_comb begin
        advance   = (mode == SENSE_DC) ? dc_under : ac_absent;
        clear_any = dc_clear || ac_clear;
    end

    disconnect_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .port_on(port_on), .tick(tick_1ms),
        .advance(advance), .clear(clear_any), .disc_req(disc_req)
    );

    a_r7_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dc_clear && ac_clear));
endmodule

// File: tb/port_discon_sense_tb.sv
module port_discon_sense_tb;
    logic clk = 0, rst_n = 0, port_on = 0, tick = 0, osc_low = 1;
    logic dc_below = 0, stb = 0, peak = 0;
    logic disc_req;
    int checks = 0, fails = 0;
    int ac_every = 0;
    logic ac_val = 0;

    always #2 clk = ~clk;

    port_discon_sense u_dut (
        .clk(clk), .rst_n(rst_n), .port_on(port_on), .tick_1ms(tick),
        .osc_tied_low(osc_low), .dc_below_min(dc_below),
        .ac_sample_stb(stb), .ac_peak_above(peak), .disc_req(disc_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue n ticks; report the tick index of the first pulse and pulse count.
    task automatic run_ticks(input int n, output int first, output int pulses);
        first = 0; pulses = 0;
        for (int i = 1; i <= n; i++) begin
            tick = 1; @(negedge clk); tick = 0;
            if (disc_req) begin pulses++; if (first == 0) first = i; end
            if (ac_every != 0 && (i % ac_every) == 0) begin
                stb = 1; peak = ac_val; @(negedge clk); stb = 0;
                if (disc_req) begin pulses++; if (first == 0) first = i; end
            end
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (disc_req) begin pulses++; if (first == 0) first = i; end
            end
        end
    endtask

    task automatic strobe(input logic v);
        stb = 1; peak = v; @(negedge clk); stb = 0; @(negedge clk);
    endtask

    task automatic power_cycle();
        port_on = 0; @(negedge clk); @(negedge clk);
        port_on = 1; @(negedge clk);
    endtask

    task automatic t_reset();
        check(disc_req == 0, "R1 in reset", disc_req, 0);
        rst_n = 1; @(negedge clk); @(negedge clk);
        check(disc_req == 0, "R1 after reset", disc_req, 0);
    endtask

    task automatic t_dc_basic();
        int f, p;
        osc_low = 1; dc_below = 1; ac_every = 0; power_cycle();
        run_ticks(360, f, p);
        check(f == 350, "R2 expiry tick", f, 350);
        check(p == 1, "R9 single pulse", p, 1);
        run_ticks(400, f, p);
        check(p == 0, "R9 saturated no repeat", p, 0);
    endtask

    task automatic t_dc_glitch();
        int f, p;
        osc_low = 1; dc_below = 1; ac_every = 0; power_cycle();
        run_ticks(100, f, p);
        dc_below = 0; run_ticks(19, f, p);
        check(p == 0, "R3 presence no pulse", p, 0);
        dc_below = 1; run_ticks(260, f, p);
        check(f == 250, "R3 short presence keeps count", f, 250);
    endtask

    task automatic t_dc_clear();
        int f, p;
        osc_low = 1; dc_below = 1; ac_every = 0; power_cycle();
        run_ticks(100, f, p);
        dc_below = 0; run_ticks(20, f, p);
        dc_below = 1; run_ticks(360, f, p);
        check(f == 350, "R4 hold clears timer", f, 350);
    endtask

    task automatic t_dc_ignores_ac();
        int f, p;
        osc_low = 1; dc_below = 1; ac_every = 9; ac_val = 1; power_cycle();
        run_ticks(360, f, p);
        check(f == 350, "R7 DC ignores good AC samples", f, 350);
        dc_below = 0; ac_val = 0; power_cycle();
        run_ticks(400, f, p);
        check(p == 0, "R7 DC ignores poor AC samples", p, 0);
    endtask

    task automatic t_ac_basic();
        int f, p;
        osc_low = 0; dc_below = 0; ac_every = 9; ac_val = 0; power_cycle();
        run_ticks(360, f, p);
        check(f == 350, "R5 AC expiry tick", f, 350);
        check(p == 1, "R5 AC single pulse", p, 1);
    endtask

    task automatic t_ac_single_good();
        int f, p;
        osc_low = 0; ac_every = 9; ac_val = 0; power_cycle();
        run_ticks(100, f, p);
        strobe(1); strobe(0);
        run_ticks(300, f, p);
        check(f == 250, "R6 lone good sample keeps count", f, 250);
    endtask

    task automatic t_ac_double_good();
        int f, p;
        osc_low = 0; ac_every = 9; ac_val = 0; power_cycle();
        run_ticks(100, f, p);
        strobe(1); strobe(1);
        run_ticks(400, f, p);
        check(f == 359, "R6 two good samples clear", f, 359);
    endtask

    task automatic t_ac_ignores_dc();
        int f, p;
        osc_low = 0; dc_below = 1; ac_every = 9; ac_val = 1; power_cycle();
        run_ticks(400, f, p);
        check(p == 0, "R7 AC ignores DC flag", p, 0);
        dc_below = 0;
    endtask

    task automatic t_port_off();
        int f, p;
        osc_low = 1; dc_below = 1; ac_every = 0; power_cycle();
        run_ticks(300, f, p);
        port_on = 0; run_ticks(60, f, p);
        check(p == 0, "R8 no pulse while off", p, 0);
        port_on = 1; @(negedge clk);
        run_ticks(360, f, p);
        check(f == 350, "R8 off clears count", f, 350);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_dc_basic();
        t_dc_glitch();
        t_dc_clear();
        t_dc_ignores_ac();
        t_ac_basic();
        t_ac_single_good();
        t_ac_double_good();
        t_ac_ignores_dc();
        t_port_off();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule